// File: doc/BRIEF.md
# Linked-Descriptor Card DMA Engine

This block moves a programmed number of bytes between a 32-bit memory port and a 32-bit card data stream. The transfer is described by a chain of descriptors held in memory. Each descriptor occupies four consecutive words: a control/status word, a buffer length in bytes, a buffer address and the address of the following descriptor. The engine fetches a descriptor and moves the bytes its buffer covers. It then hands the descriptor back to software by clearing the ownership flag in the status word and writing that word to memory. After that it either follows the link or stops.

The host side starts a transfer with a one-cycle start pulse. It supplies the list base, the total byte count, a block size and the direction, and it controls a global enable. On completion the engine sets bits in its own status register, which software clears by writing ones. For one cycle it also presents a mask of host interrupt bits to be merged into the host's raw interrupt status. One word moves per accepted beat. Each word passes through a one-word holding register between the memory side and the card side.

Top module: `desc_chain_dma`

## Requirements
- R1: A start pulse is ignored, leaving `busy_o` low and issuing no memory request, when the byte count is 0, when the block size is 0, when `dma_en_i` is low, or when the direction is card-to-memory (`dir_write_i`=0) and `card_ready_i` is low.
- R2: Each descriptor is read as four word reads at its address plus 0, 4, 8 and 12, in that order: status, size, buffer address, next address. The first descriptor sits at `list_base_i` with bits 1:0 forced to zero.
- R3: A descriptor size of 0 is treated as the maximum buffer size, and a size above the maximum is clamped to it. The maximum is 8192 bytes by default and 65536 bytes with `LARGE_BUF`=1.
- R4: Bits 1:0 of the buffer address are ignored, so every memory access is word aligned.
- R5: A descriptor moves min(its size, bytes still remaining) bytes, as ceil(n/4) consecutive words from its buffer. Memory-to-card data reaches `card_tx_data_o` in address order. Card-to-memory words are written in the order they were accepted.
- R6: After its data, each descriptor's status word is written back to its own address with bit 31 (ownership) cleared and every other bit unchanged. A descriptor that was never reached keeps bit 31 set in memory.
- R7: The walk ends after a descriptor whose status bit 2 (last) is set, or as soon as the remaining byte count reaches zero. Otherwise the next descriptor is fetched from the address in word 3.
- R8: The direction is captured at start. Changing `dir_write_i` during a transfer has no effect.
- R9: On completion `done_o` pulses for one cycle. In that cycle `host_evt_o` equals 0x00010008 (bit 3 data complete, bit 16 card interrupt), and at the next edge `stat_o` gains bit 8 (summary) plus bit 0 for memory-to-card or bit 1 for card-to-memory.
- R10: A status write clears those bits among 9:0 of `stat_o` where `stat_wdata_i` holds a 1. Bits 31:10 read as zero and are not affected. A completion set in the same cycle as a clear wins.
- R11: A memory request holds its address, direction and write data until granted. A card transmit word holds until accepted.
- R12: After reset the engine is idle, `stat_o` and `host_evt_o` are zero, and no memory request, card transmit or card receive strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle transfer start request |
| dma_en_i | input | 1 | Global engine enable |
| dir_write_i | input | 1 | 1: memory to card, 0: card to memory (sampled at start) |
| card_ready_i | input | 1 | Card has read data available |
| list_base_i | input | 32 | Address of the first descriptor |
| byte_count_i | input | 32 | Total bytes to move |
| block_size_i | input | 32 | Card block size; zero blocks a start |
| stat_wr_i | input | 1 | Status write strobe (write-one-to-clear) |
| stat_wdata_i | input | 32 | Status write data |
| stat_o | output | 32 | Engine status, bits 9:0 live |
| host_evt_o | output | 32 | One-cycle host interrupt set mask |
| busy_o | output | 1 | Engine active |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Memory beat is a write |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Memory beat accepted; read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| card_tx_valid_o | output | 1 | Word offered to the card |
| card_tx_data_o | output | 32 | Word to the card |
| card_tx_ready_i | input | 1 | Card accepts the word |
| card_rx_valid_i | input | 1 | Card offers a word |
| card_rx_data_i | input | 32 | Word from the card |
| card_rx_ready_o | output | 1 | Engine accepts the card word |

## Verification
A wrong remaining-byte or chunk counter appears at the ports as a wrong number of card beats. It also shows as a write-back to the wrong descriptor within one descriptor's worth of words, or as a hang that the transfer timeout catches. A stale link or buffer register sends the second descriptor's fetch or data beats to unexpected addresses, visible on the next fetch. A lost direction latch shows within one word, as the wrong strobe (`card_rx_ready_o` against `card_tx_valid_o`) and the wrong status bit. Status register faults are visible on `stat_o` one edge after the completion pulse or the clearing write.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_XFER, ST_WBACK, ST_NEXT, ST_DONE
  } dma_state_e;

  localparam int DESC_OWN_BIT   = 31;
  localparam int DESC_LAST_BIT  = 2;

  localparam int STAT_W         = 10;
  localparam int STAT_TX_BIT    = 0;
  localparam int STAT_RX_BIT    = 1;
  localparam int STAT_SUM_BIT   = 8;

  localparam int HOST_DONE_BIT  = 3;
  localparam int HOST_CARD_BIT  = 16;
endpackage

// File: rtl/dcd_size_clamp.sv
module dcd_size_clamp #(
  parameter bit LARGE_BUF = 1'b0,
  parameter int AW        = 32
) (
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] size_o
);
  logic [AW-1:0] max_c;

  generate
    if (LARGE_BUF) begin : g_large
      assign max_c = AW'(65536);
    end else begin : g_small
      assign max_c = AW'(8192);
    end
  endgenerate

  // zero selects the maximum; oversize is clamped
  assign size_o = ((size_i == '0) || (size_i > max_c)) ? max_c : size_i;
endmodule

// File: rtl/dcd_status_reg.sv
module dcd_status_reg
  import dcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              set_tx_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] q, clr_m, set_m;

  always_comb begin
    clr_m = wr_i ? wdata_i : '0;
    set_m = '0;
    if (set_i) begin
      set_m[STAT_SUM_BIT] = 1'b1;
      set_m[STAT_TX_BIT]  = set_tx_i;
      set_m[STAT_RX_BIT]  = ~set_tx_i;
    end
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_m) | set_m;
  end

  assign stat_o = q;
endmodule

// File: rtl/dcd_walker.sv
module dcd_walker
  import dcd_pkg::*;
#(
  parameter bit LARGE_BUF = 1'b0,
  parameter int AW        = 32,
  parameter int DW        = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dma_en_i,
  input  logic          dir_write_i,
  input  logic          card_ready_i,
  input  logic [AW-1:0] list_base_i,
  input  logic [AW-1:0] byte_count_i,
  input  logic [AW-1:0] block_size_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          card_tx_valid_o,
  output logic [DW-1:0] card_tx_data_o,
  input  logic          card_tx_ready_i,
  input  logic          card_rx_valid_i,
  input  logic [DW-1:0] card_rx_data_i,
  output logic          card_rx_ready_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          dir_wr_o
);
  localparam int BYTES_W = DW / 8;

  dma_state_e    state;
  logic [1:0]    beat;
  logic          phase;
  logic          dir_wr;
  logic [AW-1:0] cur_addr, d_next, d_buf, d_size, xaddr;
  logic [DW-1:0] d_status, wbuf;
  logic [AW-1:0] remaining, chunk_left, step, size_cl, chunk_c;
  logic          start_ok, last_word;

  dcd_size_clamp #(.LARGE_BUF(LARGE_BUF), .AW(AW)) u_clamp (
    .size_i (mem_rdata_i[AW-1:0]),
    .size_o (size_cl)
  );

  assign start_ok  = start_i && dma_en_i && (byte_count_i != '0) &&
                     (block_size_i != '0) && (dir_write_i || card_ready_i);
  assign step      = (chunk_left > AW'(BYTES_W)) ? AW'(BYTES_W) : chunk_left;
  assign last_word = (chunk_left <= AW'(BYTES_W));
  assign chunk_c   = (remaining < d_size) ? remaining : d_size;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      beat       <= '0;
      phase      <= 1'b0;
      dir_wr     <= 1'b0;
      cur_addr   <= '0;
      d_next     <= '0;
      d_buf      <= '0;
      d_size     <= '0;
      d_status   <= '0;
      xaddr      <= '0;
      wbuf       <= '0;
      remaining  <= '0;
      chunk_left <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_ok) begin
          dir_wr    <= dir_write_i;
          remaining <= byte_count_i;
          cur_addr  <= {list_base_i[AW-1:2], 2'b00};
          beat      <= '0;
          state     <= ST_FETCH;
        end
        ST_FETCH: if (mem_gnt_i) begin
          unique case (beat)
            2'd0: d_status <= mem_rdata_i;
            2'd1: d_size   <= size_cl;
            2'd2: d_buf    <= {mem_rdata_i[AW-1:2], 2'b00};
            2'd3: d_next   <= {mem_rdata_i[AW-1:2], 2'b00};
          endcase
          beat <= beat + 2'd1;
          if (beat == 2'd3) begin
            chunk_left <= chunk_c;
            xaddr      <= d_buf;
            phase      <= 1'b0;
            state      <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (!phase) begin
            if (dir_wr && mem_gnt_i) begin
              wbuf  <= mem_rdata_i;
              phase <= 1'b1;
            end else if (!dir_wr && card_rx_valid_i) begin
              wbuf  <= card_rx_data_i;
              phase <= 1'b1;
            end
          end else if (dir_wr ? card_tx_ready_i : mem_gnt_i) begin
            phase      <= 1'b0;
            xaddr      <= xaddr + AW'(BYTES_W);
            chunk_left <= chunk_left - step;
            remaining  <= remaining - step;
            if (last_word) state <= ST_WBACK;
          end
        end
        ST_WBACK: if (mem_gnt_i) state <= ST_NEXT;
        ST_NEXT: begin
          if (d_status[DESC_LAST_BIT] || (remaining == '0)) begin
            state <= ST_DONE;
          end else begin
            cur_addr <= d_next;
            beat     <= '0;
            state    <= ST_FETCH;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_addr + AW'({beat, 2'b00});
      end
      ST_XFER: begin
        mem_req_o   = (dir_wr && !phase) || (!dir_wr && phase);
        mem_we_o    = !dir_wr;
        mem_addr_o  = xaddr;
        mem_wdata_o = wbuf;
      end
      ST_WBACK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_addr;
        mem_wdata_o = d_status;
        mem_wdata_o[DESC_OWN_BIT] = 1'b0;
      end
      default: ;
    endcase
  end

  assign card_tx_valid_o = (state == ST_XFER) && phase && dir_wr;
  assign card_tx_data_o  = wbuf;
  assign card_rx_ready_o = (state == ST_XFER) && !phase && !dir_wr;
  assign busy_o          = (state != ST_IDLE);
  assign done_o          = (state == ST_DONE);
  assign dir_wr_o        = dir_wr;
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
  import dcd_pkg::*;
#(
  parameter bit LARGE_BUF = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        dma_en_i,
  input  logic        dir_write_i,
  input  logic        card_ready_i,
  input  logic [31:0] list_base_i,
  input  logic [31:0] byte_count_i,
  input  logic [31:0] block_size_i,
  input  logic        stat_wr_i,
  input  logic [31:0] stat_wdata_i,
  output logic [31:0] stat_o,
  output logic [31:0] host_evt_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_gnt_i,
  input  logic [31:0] mem_rdata_i,
  output logic        card_tx_valid_o,
  output logic [31:0] card_tx_data_o,
  input  logic        card_tx_ready_i,
  input  logic        card_rx_valid_i,
  input  logic [31:0] card_rx_data_i,
  output logic        card_rx_ready_o
);
  logic              done_w, dir_wr_w, unused_hi;
  logic [STAT_W-1:0] stat_q;

  dcd_walker #(.LARGE_BUF(LARGE_BUF), .AW(32), .DW(32)) u_walker (
    .clk_i, .rst_ni, .start_i, .dma_en_i, .dir_write_i, .card_ready_i,
    .list_base_i, .byte_count_i, .block_size_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_gnt_i, .mem_rdata_i,
    .card_tx_valid_o, .card_tx_data_o, .card_tx_ready_i,
    .card_rx_valid_i, .card_rx_data_i, .card_rx_ready_o,
    .busy_o,
    .done_o   (done_w),
    .dir_wr_o (dir_wr_w)
  );

  dcd_status_reg u_stat (
    .clk_i, .rst_ni,
    .set_i    (done_w),
    .set_tx_i (dir_wr_w),
    .wr_i     (stat_wr_i),
    .wdata_i  (stat_wdata_i[STAT_W-1:0]),
    .stat_o   (stat_q)
  );

  assign unused_hi = ^stat_wdata_i[31:STAT_W];

  always_comb begin
    host_evt_o = '0;
    host_evt_o[HOST_DONE_BIT] = done_w;
    host_evt_o[HOST_CARD_BIT] = done_w;
  end

  assign stat_o = {{(32-STAT_W){1'b0}}, stat_q};
  assign done_o = done_w;
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        dma_en_i,
  input logic [31:0] byte_count_i,
  input logic [31:0] block_size_i,
  input logic        stat_wr_i,
  input logic [31:0] stat_wdata_i,
  input logic [31:0] stat_o,
  input logic [31:0] host_evt_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_gnt_i,
  input logic        card_tx_valid_o,
  input logic [31:0] card_tx_data_o,
  input logic        card_tx_ready_i,
  input logic        card_rx_ready_o
);
  assert_ignored_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (byte_count_i == 0 || block_size_i == 0 || !dma_en_i)) |=> !busy_o);

  assert_word_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_done_then_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  assert_done_summary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> stat_o[8]);

  assert_evt_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_evt_o != 0) |=> (host_evt_o == 0));

  assert_w1c_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && !done_o) |=> ((stat_o[9:0] & $past(stat_wdata_i[9:0])) == 10'd0));

  assert_mem_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_tx_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_tx_valid_o && !card_tx_ready_i) |=> (card_tx_valid_o && $stable(card_tx_data_o)));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !card_tx_valid_o && !card_rx_ready_o));
endmodule

bind desc_chain_dma dcd_checker u_dcd_checker (.*);

// File: tb/tb_desc_chain_dma.sv
module tb_desc_chain_dma;
  localparam int MAXB  = 8192;
  localparam int MWORDS = 16384;
  localparam logic [31:0] EVT_EXP = 32'h0001_0008;

  typedef struct packed {
    logic        dir;
    logic [31:0] bc;
    logic [31:0] s0;
    logic [31:0] s1;
    logic        last0;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b1, 32'd64,   32'd32,  32'd64,    1'b0},
    '{1'b0, 32'd40,   32'd16,  32'd0,     1'b0},
    '{1'b1, 32'd10,   32'd100, 32'd64,    1'b0},
    '{1'b0, 32'd48,   32'd8,   32'd64,    1'b1},
    '{1'b1, 32'd8200, 32'd0,   32'd20000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic start_i, dma_en_i, dir_write_i, card_ready_i;
  logic [31:0] list_base_i, byte_count_i, block_size_i;
  logic stat_wr_i;
  logic [31:0] stat_wdata_i, stat_o, host_evt_o;
  logic busy_o, done_o;
  logic mem_req_o, mem_we_o, mem_gnt_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic card_tx_valid_o, card_tx_ready_i, card_rx_valid_i, card_rx_ready_o;
  logic [31:0] card_tx_data_o, card_rx_data_i;

  always #4 clk = ~clk;

  desc_chain_dma dut (
    .clk_i(clk), .rst_ni, .start_i, .dma_en_i, .dir_write_i, .card_ready_i,
    .list_base_i, .byte_count_i, .block_size_i, .stat_wr_i, .stat_wdata_i,
    .stat_o, .host_evt_o, .busy_o, .done_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_gnt_i, .mem_rdata_i,
    .card_tx_valid_o, .card_tx_data_o, .card_tx_ready_i,
    .card_rx_valid_i, .card_rx_data_i, .card_rx_ready_o
  );

  logic [31:0] mem [0:MWORDS-1];
  logic [31:0] tx_log [0:4095];
  logic [31:0] rd_log [0:3];
  int rd_cnt, tx_cnt, rx_cnt, evt_cnt, cyc;
  logic [31:0] evt_val;
  logic prep_req;
  logic [31:0] cfg_s0, cfg_s1, cfg_st0, cfg_st1;
  int n_chk, n_fail;

  assign mem_rdata_i = mem[mem_addr_o[15:2]];

  // memory and card model, all updates at the falling edge
  initial begin
    cyc = 0; rd_cnt = 0; tx_cnt = 0; rx_cnt = 0; evt_cnt = 0; evt_val = '0;
    mem_gnt_i = 1'b0; card_tx_ready_i = 1'b0; card_rx_valid_i = 1'b0;
    card_rx_data_i = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (prep_req) begin
        for (int i = 0; i < MWORDS; i++) mem[i] = 32'hA500_0000 ^ i;
        mem[16'h40] = cfg_st0; mem[16'h41] = cfg_s0;
        mem[16'h42] = 32'h0000_4002; mem[16'h43] = 32'h0000_0200;
        mem[16'h80] = cfg_st1; mem[16'h81] = cfg_s1;
        mem[16'h82] = 32'h0000_8001; mem[16'h83] = 32'h0000_0300;
        rd_cnt = 0; tx_cnt = 0; rx_cnt = 0; evt_cnt = 0; evt_val = '0;
      end
      mem_gnt_i       = (cyc % 3) != 1;
      card_tx_ready_i = (cyc % 4) != 2;
      card_rx_valid_i = (cyc % 5) != 3;
      card_rx_data_i  = 32'hC0DE_0000 + rx_cnt;
      if (mem_req_o && mem_gnt_i) begin
        if (mem_we_o) mem[mem_addr_o[15:2]] = mem_wdata_o;
        else begin
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr_o;
          rd_cnt++;
        end
      end
      if (card_tx_valid_o && card_tx_ready_i) begin
        if (tx_cnt < 4096) tx_log[tx_cnt] = card_tx_data_o;
        tx_cnt++;
      end
      if (card_rx_valid_i && card_rx_ready_o) rx_cnt++;
      if (host_evt_o != 0) begin evt_cnt++; evt_val = host_evt_o; end
    end
  end

  task automatic tick;
    @(negedge clk); #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic prep(input logic [31:0] s0, input logic [31:0] s1, input logic last0);
    cfg_s0 = s0; cfg_s1 = s1;
    cfg_st0 = 32'h8000_0018 | (last0 ? 32'h4 : 32'h0);
    cfg_st1 = 32'h8000_0014;
    prep_req = 1'b1; tick; prep_req = 1'b0;
  endtask

  task automatic launch(input logic dir, input logic [31:0] bc, input logic [31:0] bs,
                        input logic en, input logic cr);
    dir_write_i = dir; byte_count_i = bc; block_size_i = bs;
    dma_en_i = en; card_ready_i = cr; list_base_i = 32'h0000_0101;
    start_i = 1'b1; tick; start_i = 1'b0;
    dir_write_i = ~dir; // R8: direction change after start must not matter
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    while (busy_o && n < 30000) begin tick; n++; end
    chk({tag, " completes"}, {31'd0, busy_o}, 32'd0);
  endtask

  task automatic wstat(input logic [31:0] v);
    stat_wr_i = 1'b1; stat_wdata_i = v; tick; stat_wr_i = 1'b0; stat_wdata_i = '0;
  endtask

  function automatic int clampv(input logic [31:0] s);
    return (s == 0 || s > MAXB) ? MAXB : int'(s);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; prep_req = 1'b0;
    rst_ni = 1'b0; start_i = 1'b0; dma_en_i = 1'b1; dir_write_i = 1'b1;
    card_ready_i = 1'b1; list_base_i = '0; byte_count_i = '0; block_size_i = 32'd512;
    stat_wr_i = 1'b0; stat_wdata_i = '0;
    repeat (3) tick;
    rst_ni = 1'b1; tick;

    // R12 reset state
    chk("R12 busy", {31'd0, busy_o}, 32'd0);
    chk("R12 stat", stat_o, 32'd0);
    chk("R12 evt", host_evt_o, 32'd0);
    chk("R12 strobes", {29'd0, mem_req_o, card_tx_valid_o, card_rx_ready_o}, 32'd0);

    // vector table
    for (int v = 0; v < 5; v++) begin
      automatic vec_t t = VECS[v];
      automatic int c0 = (clampv(t.s0) < int'(t.bc)) ? clampv(t.s0) : int'(t.bc);
      automatic int rem = int'(t.bc) - c0;
      automatic bit use1 = !(t.last0 || rem == 0);
      automatic int c1 = use1 ? ((clampv(t.s1) < rem) ? clampv(t.s1) : rem) : 0;
      automatic int w0 = (c0 + 3) / 4;
      automatic int w1 = (c1 + 3) / 4;
      automatic int bad = 0;
      prep(t.s0, t.s1, t.last0);
      launch(t.dir, t.bc, 32'd512, 1'b1, 1'b1);
      wait_idle($sformatf("R7 vec%0d", v));
      // R2 fetch order
      chk($sformatf("R2 vec%0d fetch0", v), rd_log[0], 32'h100);
      chk($sformatf("R2 vec%0d fetch3", v), rd_log[3], 32'h10C);
      // R3 R5 R8 word count
      chk($sformatf("R5 R3 R8 vec%0d words", v), t.dir ? tx_cnt : rx_cnt, w0 + w1);
      // R4 R5 data placement
      for (int k = 0; k < w0 + w1; k++) begin
        automatic int idx = (k < w0) ? (32'h1000 + k) : (32'h2000 + k - w0);
        if (t.dir) begin
          if (tx_log[k] !== (32'hA500_0000 ^ idx)) bad++;
        end else begin
          if (mem[idx] !== (32'hC0DE_0000 + k)) bad++;
        end
      end
      chk($sformatf("R4 R5 vec%0d data mismatches", v), bad, 0);
      // R6 write-back
      chk($sformatf("R6 vec%0d desc0", v), mem[16'h40], cfg_st0 & 32'h7FFF_FFFF);
      chk($sformatf("R6 R7 vec%0d desc1", v), mem[16'h80],
          use1 ? (cfg_st1 & 32'h7FFF_FFFF) : cfg_st1);
      // R9 completion
      chk($sformatf("R9 vec%0d stat", v), stat_o, t.dir ? 32'h101 : 32'h102);
      chk($sformatf("R9 vec%0d evt count", v), evt_cnt, 1);
      chk($sformatf("R9 vec%0d evt value", v), evt_val, EVT_EXP);
      wstat(32'hFFFF_FFFF);
    end

    // R1 ignored starts
    for (int c = 0; c < 4; c++) begin
      prep(32'd16, 32'd16, 1'b1);
      case (c)
        0: launch(1'b1, 32'd0,  32'd512, 1'b1, 1'b1);
        1: launch(1'b1, 32'd16, 32'd0,   1'b1, 1'b1);
        2: launch(1'b1, 32'd16, 32'd512, 1'b0, 1'b1);
        default: launch(1'b0, 32'd16, 32'd512, 1'b1, 1'b0);
      endcase
      repeat (4) tick;
      chk($sformatf("R1 case%0d busy", c), {31'd0, busy_o}, 32'd0);
      chk($sformatf("R1 case%0d reads", c), rd_cnt, 0);
    end

    // R10 write-one-to-clear
    prep(32'd100, 32'd64, 1'b0);
    launch(1'b1, 32'd10, 32'd512, 1'b1, 1'b1);
    wait_idle("R10 setup");
    chk("R10 after run", stat_o, 32'h101);
    wstat(32'h0000_0001);
    chk("R10 clear bit0", stat_o, 32'h100);
    wstat(32'hFFFF_FC00);
    chk("R10 upper write no effect", stat_o, 32'h100);
    wstat(32'h0000_0100);
    chk("R10 clear bit8", stat_o, 32'h0);

    // R10 set wins over simultaneous clear
    prep(32'd100, 32'd64, 1'b0);
    stat_wr_i = 1'b1; stat_wdata_i = 32'h0000_0101;
    launch(1'b1, 32'd8, 32'd512, 1'b1, 1'b1);
    begin
      int n;
      n = 0;
      while (!done_o && n < 30000) begin tick; n++; end
    end
    tick;
    chk("R10 set beats clear", stat_o, 32'h101);
    stat_wr_i = 1'b0; stat_wdata_i = '0;
    tick;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule